// File: doc/BRIEF.md
# Configurable Burst Read Sequencer

This block sequences the synchronous read side of a burst-capable memory array. A small configuration register chooses between two read styles. The asynchronous style returns one word per address strobe. The synchronous style waits a programmable number of clock edges after the strobe and then streams one word per clock. The stream either counts up without limit or circles inside an aligned window of 8, 16 or 32 words. A RDY output tells the consumer when a beat is coming, either together with the first word or one clock ahead of it.

The host loads configuration bits, pulses the address strobe for one cycle with a start word address, and then takes words from `dout` while `dout_valid` is high. The array sits beside the block: `arr_addr` selects a word and `arr_data` must return it within the same cycle. The output stream has no back-pressure. Every cycle in which `dout_valid` is high carries a new word that the consumer must take. A burst runs until the next strobe or reset. A new strobe ends any read in progress. Configuration writes take effect at the next strobe. Only rising-edge clocking is implemented, and the edge-select bit is stored but has no effect.

Top module: `burst_rd_seq`

## Requirements
- R1: Reset loads the defaults: asynchronous mode, RDY with data, rising edge, continuous burst, latency code 3'b101 (7 edges). After reset `dout_valid` is 0 and `rdy` is 1.
- R2: In asynchronous mode (`cfg_wdata[7]`=1) a strobe sampled at edge 0 gives one word, mem(start), with `dout_valid` high after edge 1 only. `rdy` stays 1.
- R3: In synchronous mode (`cfg_wdata[7]`=0) with latency code n (`cfg_wdata[2:0]`), `dout_valid` is low after edges 1..n+1 and high from edge n+2 on, counting the strobe edge as 0.
- R4: With `cfg_wdata[6]`=1, `rdy` rises after the edge that brings the first word and stays high with the data.
- R5: With `cfg_wdata[6]`=0, `rdy` rises one edge before the first word (after edge n+1) and stays high.
- R6: Burst code 00 (`cfg_wdata[4:3]`) yields consecutive addresses, rolling over modulo 2^ADDR_W.
- R7: Burst codes 01, 10 and 11 step the low 3, 4 or 5 address bits modulo 8, 16 or 32 and hold every higher bit.
- R8: A write whose latency code is 3'b110 or 3'b111 keeps the previous latency and still updates all other fields.
- R9: A strobe ends any read in progress, and `dout_valid` is 0 after the strobe edge.
- R10: A configuration write during a burst does not change that burst. The next strobe uses the new values.
- R11: `cfg_wdata[5]` is stored only. It has no effect on timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock, rising edge |
| rst | input | 1 | synchronous reset, active high |
| cfg_we | input | 1 | configuration write enable |
| cfg_wdata | input | 8 | [7] mode, [6] RDY timing, [5] edge select, [4:3] burst type, [2:0] latency code |
| addr_strobe | input | 1 | one-cycle start strobe |
| strobe_addr | input | ADDR_W | start word address |
| arr_addr | output | ADDR_W | array read address |
| arr_data | input | DATA_W | array word for `arr_addr`, same cycle |
| dout | output | DATA_W | output word |
| dout_valid | output | 1 | `dout` carries a beat this cycle |
| rdy | output | 1 | ready indication |

## Verification
The bench builds the block with ADDR_W=8 and DATA_W=16. The 8-bit address space makes the top-of-space rollover in continuous bursts easy to reach, and it lets 32-word windows land at every alignment in few runs. Burst lengths reach 40 beats, so each window size wraps at least once. Random writes sometimes carry reserved latency codes and sometimes arrive in the middle of a burst.

// File: rtl/brs_pkg.sv
package brs_pkg;
  localparam int CFG_W = 8;
  localparam int LAT_W = 3;
  localparam int CNT_W = 4;

  typedef struct packed {
    logic             async_mode;
    logic             rdy_with_data;
    logic             rise_edge;
    logic [1:0]       wrap_sel;
    logic [LAT_W-1:0] lat_code;
  } brs_cfg_t;

  localparam brs_cfg_t CFG_RESET = '{async_mode: 1'b1, rdy_with_data: 1'b1,
                                     rise_edge: 1'b1, wrap_sel: 2'b00,
                                     lat_code: 3'b101};

  typedef enum logic [1:0] {ST_IDLE, ST_ASYNC, ST_WAIT, ST_BURST} brs_state_t;
endpackage

// File: rtl/brs_cfg_reg.sv
module brs_cfg_reg
  import brs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output brs_cfg_t         cfg
);
  brs_cfg_t wr;
  logic     reserved_lat;

  assign wr           = brs_cfg_t'(wdata);
  assign reserved_lat = wr.lat_code[2] & wr.lat_code[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= CFG_RESET;
    end else if (we) begin
      cfg.async_mode    <= wr.async_mode;
      cfg.rdy_with_data <= wr.rdy_with_data;
      cfg.rise_edge     <= wr.rise_edge;
      cfg.wrap_sel      <= wr.wrap_sel;
      if (!reserved_lat) cfg.lat_code <= wr.lat_code;
    end
  end
endmodule

// File: rtl/brs_addr_step.sv
module brs_addr_step #(
  parameter int ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        wrap_sel,
  output logic [ADDR_W-1:0] nxt
);
  logic [ADDR_W-1:0] cand [4];

  assign cand[0] = addr + 1'b1;

  for (genvar g = 1; g < 4; g++) begin : g_wrap
    localparam int W = g + 2;
    logic [W-1:0] low_inc;
    assign low_inc = addr[W-1:0] + 1'b1;
    assign cand[g] = {addr[ADDR_W-1:W], low_inc};
  end

  assign nxt = cand[wrap_sel];
endmodule

// File: rtl/brs_seq.sv
module brs_seq
  import brs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  brs_cfg_t          cfg,
  input  logic              strobe,
  input  logic [ADDR_W-1:0] strobe_addr,
  input  logic [DATA_W-1:0] arr_data,
  input  logic [ADDR_W-1:0] next_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [1:0]        cur_wrap,
  output logic [DATA_W-1:0] dout,
  output logic              dout_valid,
  output logic              rdy,
  output logic              bursting
);
  brs_state_t       state;
  brs_cfg_t         act;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lat;
  logic             rdy_q;

  assign lat      = CNT_W'(act.lat_code) + CNT_W'(2);
  assign cur_wrap = act.wrap_sel;
  assign bursting = (state == ST_BURST);
  assign rdy      = act.async_mode | rdy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      act        <= CFG_RESET;
      cnt        <= '0;
      cur_addr   <= '0;
      dout       <= '0;
      dout_valid <= 1'b0;
      rdy_q      <= 1'b0;
    end else if (strobe) begin
      act        <= cfg;
      cur_addr   <= strobe_addr;
      cnt        <= CNT_W'(1);
      dout_valid <= 1'b0;
      rdy_q      <= 1'b0;
      state      <= cfg.async_mode ? ST_ASYNC : ST_WAIT;
    end else begin
      unique case (state)
        ST_IDLE: dout_valid <= 1'b0;
        ST_ASYNC: begin
          dout       <= arr_data;
          dout_valid <= 1'b1;
          state      <= ST_IDLE;
        end
        ST_WAIT: begin
          if (cnt == lat) begin
            dout       <= arr_data;
            dout_valid <= 1'b1;
            rdy_q      <= 1'b1;
            cur_addr   <= next_addr;
            state      <= ST_BURST;
          end else begin
            cnt <= cnt + 1'b1;
            if (!act.rdy_with_data && (cnt == lat - 1'b1)) rdy_q <= 1'b1;
          end
        end
        ST_BURST: begin
          dout       <= arr_data;
          dout_valid <= 1'b1;
          cur_addr   <= next_addr;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/burst_rd_seq.sv
module burst_rd_seq
  import brs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  input  logic              addr_strobe,
  input  logic [ADDR_W-1:0] strobe_addr,
  output logic [ADDR_W-1:0] arr_addr,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] dout,
  output logic              dout_valid,
  output logic              rdy
);
  brs_cfg_t          cfg;
  logic [ADDR_W-1:0] nxt;
  logic [1:0]        cur_wrap;
  logic              bursting_w;

  brs_cfg_reg u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  brs_addr_step #(.ADDR_W(ADDR_W)) u_step (
    .addr     (arr_addr),
    .wrap_sel (cur_wrap),
    .nxt      (nxt)
  );

  brs_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .cfg         (cfg),
    .strobe      (addr_strobe),
    .strobe_addr (strobe_addr),
    .arr_data    (arr_data),
    .next_addr   (nxt),
    .cur_addr    (arr_addr),
    .cur_wrap    (cur_wrap),
    .dout        (dout),
    .dout_valid  (dout_valid),
    .rdy         (rdy),
    .bursting    (bursting_w)
  );
endmodule

// File: rtl/brs_chk.sv
module brs_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              strobe,
  input logic              dout_valid,
  input logic              rdy,
  input logic              bursting,
  input logic [1:0]        wrap_sel,
  input logic [ADDR_W-1:0] arr_addr
);
  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !dout_valid);

  p_async_single_r2: assert property (@(posedge clk) disable iff (rst)
    (dout_valid && !bursting) |=> !dout_valid);

  p_valid_has_rdy_r4: assert property (@(posedge clk) disable iff (rst)
    dout_valid |-> rdy);

  p_rdy_lead_r5: assert property (@(posedge clk) disable iff (rst)
    ($rose(rdy) && !dout_valid && !strobe) |=> dout_valid);

  p_cont_step_r6: assert property (@(posedge clk) disable iff (rst)
    (bursting && !strobe && wrap_sel == 2'b00) |=>
      arr_addr == ADDR_W'($past(arr_addr) + 1'b1));

  p_wrap_upper_r7: assert property (@(posedge clk) disable iff (rst)
    (bursting && !strobe && wrap_sel != 2'b00) |=>
      arr_addr[ADDR_W-1:5] == $past(arr_addr[ADDR_W-1:5]));

  p_strobe_ends_r9: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !dout_valid);
endmodule

bind burst_rd_seq brs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .strobe     (addr_strobe),
  .dout_valid (dout_valid),
  .rdy        (rdy),
  .bursting   (bursting_w),
  .wrap_sel   (cur_wrap),
  .arr_addr   (arr_addr)
);

// File: tb/burst_rd_seq_tb.sv
module burst_rd_seq_tb;
  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [7:0]    cfg_wdata = '0;
  logic          addr_strobe = 1'b0;
  logic [AW-1:0] strobe_addr = '0;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_data;
  logic [DW-1:0] dout;
  logic          dout_valid;
  logic          rdy;

  int total = 0;
  int bad   = 0;

  bit       m_async = 1'b1;
  bit       m_lead  = 1'b0;
  bit [1:0] m_sel   = 2'b00;
  bit [2:0] m_code  = 3'b101;

  always #10 clk = ~clk;

  burst_rd_seq #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .addr_strobe(addr_strobe), .strobe_addr(strobe_addr), .arr_addr(arr_addr),
    .arr_data(arr_data), .dout(dout), .dout_valid(dout_valid), .rdy(rdy)
  );

  function automatic logic [DW-1:0] mem(input logic [AW-1:0] a);
    return DW'(({8'h00, a} * 16'h9E37) ^ 16'h5A5A);
  endfunction

  always_comb arr_data = mem(arr_addr);

  function automatic logic [AW-1:0] step(input logic [AW-1:0] a, input bit [1:0] sel);
    int n, base, off;
    if (sel == 2'b00) return AW'(a + 1);
    n    = 8 << (sel - 1);
    off  = int'(a) % n;
    base = int'(a) - off;
    return AW'(base + (off + 1) % n);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void apply_model(input logic [7:0] w);
    m_async = w[7];
    m_lead  = !w[6];
    m_sel   = w[4:3];
    if (w[2:1] != 2'b11) m_code = w[2:0];
  endfunction

  task automatic write_cfg(input logic [7:0] w);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
    apply_model(w);
  endtask

  task automatic run_burst(input logic [AW-1:0] addr, input int beats, input bit mid);
    bit            a    = m_async;
    bit            lead = m_lead;
    bit [1:0]      sel  = m_sel;
    int            lat  = int'(m_code) + 2;
    logic [AW-1:0] exp  = addr;
    logic [7:0]    pend = 8'h00;
    string         areq;
    @(negedge clk);
    addr_strobe = 1'b1;
    strobe_addr = addr;
    @(negedge clk);
    addr_strobe = 1'b0;
    chk(dout_valid == 1'b0, "R9 valid after strobe", dout_valid, 0);
    if (a) begin
      @(negedge clk);
      chk(dout_valid == 1'b1, "R2 single beat", dout_valid, 1);
      chk(dout == mem(addr), "R2 word", dout, mem(addr));
      chk(rdy == 1'b1, "R2 rdy", rdy, 1);
      @(negedge clk);
      chk(dout_valid == 1'b0, "R2 no second beat", dout_valid, 0);
      chk(rdy == 1'b1, "R2 rdy idle", rdy, 1);
    end else begin
      areq = (sel == 2'b00) ? "R6 address" : "R7 address";
      for (int k = 1; k < lat + beats; k++) begin
        @(negedge clk);
        if (mid && k == lat + 2) cfg_we = 1'b0;
        if (k < lat) begin
          chk(dout_valid == 1'b0, "R3 latency", dout_valid, 0);
          if (lead) chk(rdy == (k == lat - 1), "R5 rdy lead", rdy, int'(k == lat - 1));
          else      chk(rdy == 1'b0, "R4 rdy wait", rdy, 0);
        end else begin
          chk(dout_valid == 1'b1, "R3 beat", dout_valid, 1);
          chk(dout == mem(exp), mid ? "R10 data" : areq, dout, mem(exp));
          chk(rdy == 1'b1, lead ? "R5 rdy hold" : "R4 rdy with data", rdy, 1);
          exp = step(exp, sel);
        end
        if (mid && k == lat + 1) begin
          pend = 8'($urandom);
          cfg_we = 1'b1;
          cfg_wdata = pend;
        end
      end
      if (mid) apply_model(pend);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(dout_valid == 1'b0, "R1 valid after reset", dout_valid, 0);
    chk(rdy == 1'b1, "R1 rdy after reset", rdy, 1);
    run_burst(8'h3C, 1, 1'b0);                 // R1 default asynchronous
    // R8 + R1: reserved code keeps default latency of 7 while mode changes
    write_cfg({1'b0, 1'b1, 1'b1, 2'b00, 3'b111});
    run_burst(8'hFC, 10, 1'b0);                // R6 rollover at top
    write_cfg({1'b0, 1'b0, 1'b1, 2'b01, 3'b000});
    run_burst(8'h35, 12, 1'b0);                // R5 shortest latency, R7 8-word
    write_cfg({1'b0, 1'b1, 1'b0, 2'b10, 3'b101}); // R11 edge bit cleared
    run_burst(8'h4E, 20, 1'b0);
    write_cfg({1'b0, 1'b0, 1'b1, 2'b11, 3'b110}); // R8 reserved, latency kept
    run_burst(8'hDD, 40, 1'b1);                // R7 32-word, R10 mid write
    write_cfg({1'b1, 1'b0, 1'b1, 2'b10, 3'b010});
    run_burst(8'h81, 1, 1'b0);
    for (int i = 0; i < 30; i++) begin
      if ($urandom % 3 != 0) write_cfg(8'($urandom) & 8'h7F);
      else write_cfg(8'($urandom));
      run_burst(AW'($urandom), 5 + int'($urandom % 36), ($urandom % 4) == 0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule